// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a set of hardware semaphore latches that two independent ports, called left and right, use to claim shared resources. A port addresses one latch through the low bits of its address bus while its semaphore select is active. It then writes or reads that latch. On a write only data bit 0 counts: a zero asks for the latch and a one gives it up. A read returns how that port sees ownership. A zero means "you own it" and a one means "you do not". The value is copied onto every data bit.

Each latch shows opposite views to the two ports. A port that asks for a latch the other side holds is remembered as waiting. When the holder lets go, ownership passes to the waiting port with no further write. Read data is captured in a per-port register, so a write by the other port in the same cycle cannot disturb a value that is being read. If both ports ask for a free latch in the same cycle, a fixed priority picks the winner, and the loser waits.

Top module: `sem_bank`

## Requirements
- R1: The bank holds NUM_SEM latches (default 8). The latch is selected by the low log2(NUM_SEM) address bits (3 bits by default). Higher address bits have no effect.
- R2: On a write (`*_sel`=1, `*_we`=1) only data bit 0 is used: 0 requests the latch and 1 releases it. The other data bits have no effect.
- R3: When a port requests a free latch, that port then reads all zeros at that address and the opposite port reads all ones.
- R4: Only the owner can change a latch. A request written by the owner has no effect. A release written by the owner, with nothing pending, frees the latch, and both ports then read ones. A release written by a non-owner that has nothing pending has no effect.
- R5: A request from the non-owner while the latch is held stays pending. On the owner's release, ownership passes to that port, which then reads zeros while the former owner reads ones.
- R6: A non-owner that writes 1 cancels its own pending request, so a later release by the owner leaves the latch free.
- R7: When both ports request the same free latch in one cycle, exactly one becomes owner: the left port when LEFT_WINS=1, the right port when LEFT_WINS=0. The other port's request is held pending.
- R8: A read (`*_sel`=1, `*_we`=0) loads the port's view of the latch, replicated on all DATA_W bits, into `*_rdata` at the clock edge. The value reflects the state before any write taking effect at that same edge. It holds until that port's next read.
- R9: After reset every latch is free, nothing is pending, and both `*_rdata` outputs are all ones.
- R10: At no time do both ports own the same latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port semaphore select |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_addr | input | ADR_W | Left port address, low bits pick the latch |
| l_wdata | input | DATA_W | Left port write data, bit 0 used |
| l_rdata | output | DATA_W | Left port registered read value |
| r_sel | input | 1 | Right port semaphore select |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_addr | input | ADR_W | Right port address, low bits pick the latch |
| r_wdata | input | DATA_W | Right port write data, bit 0 used |
| r_rdata | output | DATA_W | Right port registered read value |

## Verification
The bench builds the block with eight latches, a 16-bit address and an 8-bit data bus, with left priority. The wide address lets it set upper address bits that must be ignored. The 8-bit data lets it check that bits 7:1 of a write are discarded and that reads copy the view onto every bit. The single-cycle port model lets both ports act at the same edge. That covers the tie between two requests, a hand-over to a waiting port, and a read that overlaps the other port's release.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } own_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
   parameter int NUM_SEM = 8,
   parameter int ADR_W   = 16,
   parameter int DATA_W  = 8,
   localparam int SEL_W  = $clog2(NUM_SEM)
) (
   input  logic               sel,
   input  logic               we,
   input  logic [ADR_W-1:0]   addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SEM-1:0] req,
   output logic [NUM_SEM-1:0] rel,
   output logic               rd_en,
   output logic [SEL_W-1:0]   idx
);
   logic wr_en;

   assign idx   = addr[SEL_W-1:0];
   assign wr_en = sel & we;
   assign rd_en = sel & ~we;

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
      assign req[g] = wr_en & (idx == SEL_W'(g)) & ~wdata[0];
      assign rel[g] = wr_en & (idx == SEL_W'(g)) &  wdata[0];
   end

   if (DATA_W > 1) begin : g_dbits
      logic unused_dbits;
      assign unused_dbits = ^wdata[DATA_W-1:1];
   end
   if (ADR_W > SEL_W) begin : g_abits
      logic unused_abits;
      assign unused_abits = ^addr[ADR_W-1:SEL_W];
   end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_pkg::*;
#(
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l_req,
   input  logic l_rel,
   input  logic r_req,
   input  logic r_rel,
   output logic own_l,
   output logic own_r
);
   own_e st_q, st_d;
   logic pend_l_q, pend_l_d, pend_r_q, pend_r_d;
   logic wait_l, wait_r, tie_left;

   if (LEFT_WINS) begin : g_prio_left
      assign tie_left = 1'b1;
   end else begin : g_prio_right
      assign tie_left = 1'b0;
   end

   assign wait_l = (pend_l_q | l_req) & ~l_rel;
   assign wait_r = (pend_r_q | r_req) & ~r_rel;

   always_comb begin
      st_d     = st_q;
      pend_l_d = pend_l_q;
      pend_r_d = pend_r_q;
      unique case (st_q)
         OWN_NONE: begin
            if (l_req && r_req) begin
               if (tie_left) begin
                  st_d     = OWN_LEFT;
                  pend_r_d = 1'b1;
               end else begin
                  st_d     = OWN_RIGHT;
                  pend_l_d = 1'b1;
               end
            end else if (l_req) begin
               st_d = OWN_LEFT;
            end else if (r_req) begin
               st_d = OWN_RIGHT;
            end
         end
         OWN_LEFT: begin
            pend_r_d = wait_r;
            if (l_rel) begin
               st_d     = wait_r ? OWN_RIGHT : OWN_NONE;
               pend_r_d = 1'b0;
            end
         end
         OWN_RIGHT: begin
            pend_l_d = wait_l;
            if (r_rel) begin
               st_d     = wait_l ? OWN_LEFT : OWN_NONE;
               pend_l_d = 1'b0;
            end
         end
         default: begin
            st_d     = OWN_NONE;
            pend_l_d = 1'b0;
            pend_r_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= OWN_NONE;
         pend_l_q <= 1'b0;
         pend_r_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         pend_l_q <= pend_l_d;
         pend_r_q <= pend_r_d;
      end
   end

   assign own_l = (st_q == OWN_LEFT);
   assign own_r = (st_q == OWN_RIGHT);
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              view,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '1;
      else if (rd_en) rdata <= {DATA_W{view}};
   end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM   = 8,
   parameter int ADR_W     = 16,
   parameter int DATA_W    = 8,
   parameter bit LEFT_WINS = 1'b1,
   localparam int SEL_W    = $clog2(NUM_SEM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_we,
   input  logic [ADR_W-1:0]  l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sel,
   input  logic              r_we,
   input  logic [ADR_W-1:0]  r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   if (NUM_SEM < 2 || (1 << SEL_W) != NUM_SEM) begin : g_bad_num
      $error("sem_bank: NUM_SEM must be a power of two, at least 2");
   end
   if (ADR_W < SEL_W) begin : g_bad_adr
      $error("sem_bank: ADR_W narrower than the latch index");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("sem_bank: DATA_W must be at least 1");
   end

   logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
   logic [NUM_SEM-1:0] own_l_v, own_r_v;
   logic               l_rd, r_rd;
   logic [SEL_W-1:0]   l_idx, r_idx;

   sem_port_dec #(.NUM_SEM(NUM_SEM), .ADR_W(ADR_W), .DATA_W(DATA_W)) u_ldec (
      .sel(l_sel), .we(l_we), .addr(l_addr), .wdata(l_wdata),
      .req(l_req), .rel(l_rel), .rd_en(l_rd), .idx(l_idx));

   sem_port_dec #(.NUM_SEM(NUM_SEM), .ADR_W(ADR_W), .DATA_W(DATA_W)) u_rdec (
      .sel(r_sel), .we(r_we), .addr(r_addr), .wdata(r_wdata),
      .req(r_req), .rel(r_rel), .rd_en(r_rd), .idx(r_idx));

   for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
      sem_cell #(.LEFT_WINS(LEFT_WINS)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_req(l_req[g]), .l_rel(l_rel[g]),
         .r_req(r_req[g]), .r_rel(r_rel[g]),
         .own_l(own_l_v[g]), .own_r(own_r_v[g]));
   end

   sem_rd_reg #(.DATA_W(DATA_W)) u_lrd (
      .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .view(~own_l_v[l_idx]), .rdata(l_rdata));

   sem_rd_reg #(.DATA_W(DATA_W)) u_rrd (
      .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .view(~own_r_v[r_idx]), .rdata(r_rdata));
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
   parameter int NUM_SEM = 8,
   parameter int ADR_W   = 16,
   parameter int DATA_W  = 8,
   localparam int SEL_W  = $clog2(NUM_SEM)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               l_sel,
   input logic               l_we,
   input logic [ADR_W-1:0]   l_addr,
   input logic [DATA_W-1:0]  l_wdata,
   input logic [DATA_W-1:0]  l_rdata,
   input logic               r_sel,
   input logic               r_we,
   input logic [ADR_W-1:0]   r_addr,
   input logic [DATA_W-1:0]  r_rdata,
   input logic [NUM_SEM-1:0] own_l_v,
   input logic [NUM_SEM-1:0] own_r_v
);
   logic [SEL_W-1:0] li, ri;
   assign li = l_addr[SEL_W-1:0];
   assign ri = r_addr[SEL_W-1:0];

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l_v & own_r_v) == '0); // R10

   AST_NO_DUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && !l_we && r_sel && !r_we && li == ri) |=> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0)); // R10

   AST_L_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_sel && !l_we) |=> $stable(l_rdata)); // R8

   AST_R_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_sel && !r_we) |=> $stable(r_rdata)); // R8

   AST_L_RD_REPL: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rdata == '0) || (l_rdata == '1)); // R8

   AST_OWNER_REQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && l_we && !l_wdata[0] && own_l_v[li]) |=> own_l_v[$past(li)]); // R4

   AST_OWNER_REL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && l_we && l_wdata[0] && own_l_v[li]) |=> !own_l_v[$past(li)]); // R5
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .ADR_W(ADR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
   .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_rdata(r_rdata),
   .own_l_v(own_l_v), .own_r_v(own_r_v));

// File: tb/sim_sem_bank.sv
`timescale 1ns/1ps
module sim_sem_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_sel = 0, l_we = 0, r_sel = 0, r_we = 0;
   logic [15:0] l_addr = '0, r_addr = '0;
   logic [7:0]  l_wdata = '0, r_wdata = '0;
   logic [7:0]  l_rdata, r_rdata;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sem_bank #(.NUM_SEM(8), .ADR_W(16), .DATA_W(8), .LEFT_WINS(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // one cycle of activity on both ports, then both idle; returns at a negedge
   task automatic step(input logic ls, input logic lw, input logic [15:0] la, input logic [7:0] ld,
                       input logic rs, input logic rw, input logic [15:0] ra, input logic [7:0] rd);
      @(negedge clk);
      l_sel = ls; l_we = lw; l_addr = la; l_wdata = ld;
      r_sel = rs; r_we = rw; r_addr = ra; r_wdata = rd;
      @(negedge clk);
      l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
   endtask

   task automatic lwr(input logic [15:0] a, input logic [7:0] d);
      step(1, 1, a, d, 0, 0, '0, '0);
   endtask
   task automatic rwr(input logic [15:0] a, input logic [7:0] d);
      step(0, 0, '0, '0, 1, 1, a, d);
   endtask
   task automatic rd_both(input logic [15:0] a, input logic [7:0] el, input logic [7:0] er,
                          input string tag);
      step(1, 0, a, '0, 1, 0, a, '0);
      chk({tag, " left"},  l_rdata, el);
      chk({tag, " right"}, r_rdata, er);
   endtask

   task automatic t_reset();
      chk("R9 rdata after reset left",  l_rdata, 8'hFF);
      chk("R9 rdata after reset right", r_rdata, 8'hFF);
      for (int i = 0; i < 8; i++) rd_both(16'(i), 8'hFF, 8'hFF, "R9 free at reset");
   endtask

   task automatic t_request();
      lwr(16'd2, 8'h00);
      rd_both(16'd2, 8'h00, 8'hFF, "R3 left takes free sem");
      lwr(16'd2, 8'h00);
      rd_both(16'd2, 8'h00, 8'hFF, "R4 owner request no effect");
      rwr(16'd2, 8'h01);
      rd_both(16'd2, 8'h00, 8'hFF, "R4 non-owner release no effect");
      lwr(16'd2, 8'h01);
      rd_both(16'd2, 8'hFF, 8'hFF, "R4 owner release frees");
   endtask

   task automatic t_transfer();
      lwr(16'd4, 8'h00);
      rwr(16'd4, 8'h00);
      rd_both(16'd4, 8'h00, 8'hFF, "R5 pending waits");
      lwr(16'd4, 8'h01);
      rd_both(16'd4, 8'hFF, 8'h00, "R5 hand-over on release");
      rwr(16'd4, 8'h01);
      rd_both(16'd4, 8'hFF, 8'hFF, "R5 cleanup");
   endtask

   task automatic t_cancel();
      lwr(16'd3, 8'h00);
      rwr(16'd3, 8'h00);
      rwr(16'd3, 8'h01);
      lwr(16'd3, 8'h01);
      rd_both(16'd3, 8'hFF, 8'hFF, "R6 cancelled request");
   endtask

   task automatic t_tie();
      step(1, 1, 16'd1, 8'h00, 1, 1, 16'd1, 8'h00);
      rd_both(16'd1, 8'h00, 8'hFF, "R7 left wins tie");
      lwr(16'd1, 8'h01);
      rd_both(16'd1, 8'hFF, 8'h00, "R7 loser pending");
      rwr(16'd1, 8'h01);
   endtask

   task automatic t_addr_data();
      lwr(16'hABC5, 8'hFE);
      rd_both(16'h0005, 8'h00, 8'hFF, "R1 upper addr ignored, R2 bit0 request");
      rd_both(16'h0000, 8'hFF, 8'hFF, "R1 other sem untouched");
      lwr(16'h7F05, 8'h01);
      rd_both(16'h0005, 8'hFF, 8'hFF, "R2 bit0 release");
   endtask

   task automatic t_read_latch();
      rwr(16'd6, 8'h00);
      lwr(16'd6, 8'h00);
      step(1, 0, 16'd6, '0, 1, 1, 16'd6, 8'h01);
      chk("R8 read sees pre-edge state", l_rdata, 8'hFF);
      @(negedge clk);
      chk("R8 read value held", l_rdata, 8'hFF);
      rd_both(16'd6, 8'h00, 8'hFF, "R8 new read after hand-over");
      lwr(16'd6, 8'h01);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_request();
      t_transfer();
      t_cancel();
      t_tie();
      t_addr_data();
      t_read_latch();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule